// File: doc/BRIEF.md
# I2C Slave Memory-Emulation Controller

This block lets an external I2C master use a region of on-chip RAM as if it were a small serial EEPROM. It watches the bus for its own 7-bit device address. After a write-direction address it takes one byte as a memory pointer, then stores any data bytes that follow. Page writes wrap inside a page whose length software selects. Read-direction accesses stream bytes out of the RAM, starting at the current pointer, for as long as the master acknowledges them.

Every RAM access goes through a request/acknowledge port. The request stays raised until the memory acknowledges it. A small register file holds the following state:
- the page length and the interrupt enable;
- a busy lock, which the hardware raises after each transaction that wrote data;
- event flags that clear when they are read;
- the byte count and the current pointer.

While the lock is set the slave does not acknowledge its address. Software saves what it needs and then clears the lock to re-open the slave.

Top module: `i2cmem_slave`

## Requirements
- R1: The slave acknowledges only its own 7-bit device address (default 0x50, the R/W bit is the LSB of the first byte, 1 = read). Any other address gets no acknowledge, and the rest of that transaction is ignored.
- R2: After a write-direction address, the next byte is acknowledged and loaded into the current pointer. The pointer can be read back at register index 4.
- R3: Each received data byte raises `ram_req` with `ram_we`=1, the byte, and the current pointer as address. The request and its address stay stable until `ram_ack`.
- R4: Successive data bytes in one transaction advance the pointer by one. At the end of a page the pointer wraps to the first byte of the same page. The page length comes from register 0 bits 7:6: 00 = 8, 01 = 16, 10 = 32, 11 = 64 bytes.
- R5: The current pointer equals the last accessed location plus one (after a page wrap, its wrapped successor). A read with no preceding address byte returns the byte at the pointer.
- R6: A pointer-only write followed by a repeated start with the read bit returns data from the loaded pointer. A pointer-only write ended by a stop, followed by a separate read, returns the same data.
- R7: A read keeps sending consecutive bytes while the master acknowledges, and wraps from 0xFF to 0x00. A not-acknowledge ends the read, and the slave leaves SDA released.
- R8: When a transaction that wrote at least one data byte ends (stop or repeated start), register 1 bit 0 (busy) is set. While busy is set the device address is not acknowledged. Writing 0 to register 1 bit 0 clears busy, and writing 1 has no effect.
- R9: Register 3 holds the number of data bytes written or read in the most recent transaction. It is cleared at a start only when the slave is not locked.
- R10: Register 2 (status) holds three flags: bit 0 = write transaction done, bit 1 = read transaction done, bit 2 = address matched. Reading register 2 clears the flags. `irq` is high when register 0 bit 0 is set and any flag is set.
- R11: After reset all registers read zero, and `sda_oe`, `irq` and `ram_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High pulls the data line low |
| ram_req | output | 1 | RAM transfer request |
| ram_we | output | 1 | 1 = write, 0 = read |
| ram_addr | output | 8 | RAM byte address |
| ram_wdata | output | 8 | Byte to store |
| ram_ack | input | 1 | RAM completes the request |
| ram_rdata | input | 8 | Byte returned by the RAM, valid with `ram_ack` |
| reg_sel | input | 3 | Register index (0 ctrl, 1 lock, 2 status, 3 count, 4 pointer) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status when index is 2) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq | output | 1 | Interrupt request |

## Verification
The main path is exercised by page writes whose start pointer, length and page size are all drawn at random. These runs show whether the wrap is bounded by the selected page or by the whole memory. Random reads started by a repeated start are compared with reads that follow a separate pointer-only write and stop; a mismatch between the two exposes a pointer loaded at the wrong moment. Directed cases cover the rest:
- a read that crosses 0xFF, which checks the roll-over;
- a wrong device address, which should get no acknowledge;
- an access while locked, which should be refused and should leave the byte count unchanged;
- a status read, which should clear both the flags and the interrupt.

// File: rtl/i2cmem_pkg.sv
`timescale 1ns/1ps
package i2cmem_pkg;
  localparam int MEM_AW = 8;
  localparam int SEL_W  = 3;

  localparam logic [SEL_W-1:0] RIX_CTRL  = 3'd0;
  localparam logic [SEL_W-1:0] RIX_LOCK  = 3'd1;
  localparam logic [SEL_W-1:0] RIX_STAT  = 3'd2;
  localparam logic [SEL_W-1:0] RIX_COUNT = 3'd3;
  localparam logic [SEL_W-1:0] RIX_PTR   = 3'd4;

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_ACK_DEV, S_WADDR, S_ACK_ADDR,
    S_WDATA, S_ACK_DATA, S_RDATA, S_RACK, S_WAITP
  } link_state_e;

  // low-bit mask of a page: 8 << sel bytes
  function automatic logic [MEM_AW-1:0] page_mask(input logic [1:0] sel);
    return MEM_AW'((8 << sel) - 1);
  endfunction

  // next write pointer, wrapping inside the page
  function automatic logic [MEM_AW-1:0] page_step(input logic [MEM_AW-1:0] a,
                                                  input logic [1:0] sel);
    logic [MEM_AW-1:0] m;
    m = page_mask(sel);
    return (a & ~m) | ((a + 1'b1) & m);
  endfunction
endpackage

// File: rtl/i2cmem_lines.sv
`timescale 1ns/1ps
module i2cmem_lines #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_p, sda_p;
  logic scl_s, scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl_i};
      sda_p <= {sda_p[STAGES-2:0], sda_i};
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_s    = scl_p[STAGES-1];
  assign sda_s    = sda_p[STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2cmem_ramport.sv
`timescale 1ns/1ps
module i2cmem_ramport #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_go,
  input  logic          wr_go,
  input  logic [AW-1:0] go_addr,
  input  logic [DW-1:0] go_wdata,
  output logic          ram_req,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  input  logic          ram_ack,
  input  logic [DW-1:0] ram_rdata,
  output logic [DW-1:0] rd_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_req   <= 1'b0;
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
      rd_q      <= '0;
    end else begin
      if (ram_req && ram_ack) begin
        ram_req <= 1'b0;
        if (!ram_we) rd_q <= ram_rdata;
      end
      if (rd_go || wr_go) begin
        ram_req   <= 1'b1;
        ram_we    <= wr_go;
        ram_addr  <= go_addr;
        ram_wdata <= go_wdata;
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ram_req && !ram_ack |=> ram_req && $stable(ram_addr) && $stable(ram_we)); // R3
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go || wr_go) |-> !(ram_req && !ram_ack)); // R3
endmodule

// File: rtl/i2cmem_regs.sv
`timescale 1ns/1ps
module i2cmem_regs
  import i2cmem_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              set_busy,
  input  logic              ev_wdone,
  input  logic              ev_rdone,
  input  logic              ev_match,
  input  logic [MEM_AW-1:0] cur_addr,
  input  logic [CNT_W-1:0]  byte_cnt,
  output logic [1:0]        page_len,
  output logic              busy,
  output logic              irq
);
  logic [7:0] ctrl_q;
  logic [2:0] flags_q, flags_set;
  logic       flags_clr;

  assign flags_set = {ev_match, ev_rdone, ev_wdone};
  assign flags_clr = reg_rd && (reg_sel == RIX_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      busy    <= 1'b0;
      flags_q <= '0;
    end else begin
      if (reg_wr && reg_sel == RIX_CTRL) ctrl_q <= reg_wdata;
      if (set_busy) busy <= 1'b1;
      else if (reg_wr && reg_sel == RIX_LOCK && !reg_wdata[0]) busy <= 1'b0;
      flags_q <= (flags_clr ? 3'b000 : flags_q) | flags_set;
    end
  end

  assign page_len = ctrl_q[7:6];
  assign irq      = ctrl_q[0] & (|flags_q);

  always_comb begin
    case (reg_sel)
      RIX_CTRL:  reg_rdata = ctrl_q;
      RIX_LOCK:  reg_rdata = {7'd0, busy};
      RIX_STAT:  reg_rdata = {5'd0, flags_q};
      RIX_COUNT: reg_rdata = 8'(byte_cnt);
      RIX_PTR:   reg_rdata = 8'(cur_addr);
      default:   reg_rdata = 8'd0;
    endcase
  end

  AST_STATUS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flags_clr && flags_set == 3'b000 |=> flags_q == 3'b000); // R10
  AST_LOCK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_sel == RIX_LOCK && !reg_wdata[0] && !set_busy |=> !busy); // R8
endmodule

// File: rtl/i2cmem_slave.sv
`timescale 1ns/1ps
module i2cmem_slave
  import i2cmem_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         SYNC_STAGES = 2,
  parameter int         CNT_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              ram_req,
  output logic              ram_we,
  output logic [MEM_AW-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  input  logic              ram_ack,
  input  logic [7:0]        ram_rdata,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq
);
  logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  link_state_e state;
  logic [3:0]        bitcnt;
  logic [7:0]        rx_sh, rd_q;
  logic [6:0]        tx_sh;
  logic              rw_q, mack_q, txn_wr, txn_rd;
  logic [MEM_AW-1:0] cur_addr, go_addr;
  logic [CNT_W-1:0]  byte_cnt;
  logic [1:0]        page_len;
  logic              busy;

  // named internal events
  logic txn_end, byte_in, dev_hit, wr_fire, rd_byte_done, rd_go;
  assign txn_end      = start_ev | stop_ev;
  assign byte_in      = scl_fall && bitcnt == 4'd8 && !txn_end;
  assign dev_hit      = byte_in && state == S_DEV && rx_sh[7:1] == DEV_ADDR && !busy;
  assign wr_fire      = byte_in && state == S_WDATA;
  assign rd_byte_done = scl_fall && state == S_RDATA && bitcnt == 4'd7 && !txn_end;
  assign rd_go        = (dev_hit && rx_sh[0]) || rd_byte_done;
  assign go_addr      = rd_byte_done ? MEM_AW'(cur_addr + 1'b1) : cur_addr;

  i2cmem_lines #(.STAGES(SYNC_STAGES)) u_lines (
    .clk, .rst_n, .scl_i, .sda_i, .sda_s,
    .scl_rise, .scl_fall, .start_ev, .stop_ev
  );

  i2cmem_ramport #(.AW(MEM_AW), .DW(8)) u_ram (
    .clk, .rst_n, .rd_go, .wr_go(wr_fire), .go_addr, .go_wdata(rx_sh),
    .ram_req, .ram_we, .ram_addr, .ram_wdata, .ram_ack, .ram_rdata, .rd_q
  );

  i2cmem_regs #(.CNT_W(CNT_W)) u_regs (
    .clk, .rst_n, .reg_sel, .reg_wr, .reg_rd, .reg_wdata, .reg_rdata,
    .set_busy(txn_end && txn_wr), .ev_wdone(txn_end && txn_wr),
    .ev_rdone(txn_end && txn_rd), .ev_match(dev_hit),
    .cur_addr, .byte_cnt, .page_len, .busy, .irq
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      bitcnt   <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      rw_q     <= 1'b0;
      mack_q   <= 1'b0;
      txn_wr   <= 1'b0;
      txn_rd   <= 1'b0;
      cur_addr <= '0;
      byte_cnt <= '0;
      sda_oe   <= 1'b0;
    end else if (start_ev) begin
      state  <= S_DEV;
      bitcnt <= '0;
      sda_oe <= 1'b0;
      txn_wr <= 1'b0;
      txn_rd <= 1'b0;
      if (!busy && !txn_wr) byte_cnt <= '0;
    end else if (stop_ev) begin
      state  <= S_IDLE;
      sda_oe <= 1'b0;
      txn_wr <= 1'b0;
      txn_rd <= 1'b0;
    end else begin
      if (scl_rise && (state == S_DEV || state == S_WADDR || state == S_WDATA)
          && bitcnt < 4'd8) begin
        rx_sh  <= {rx_sh[6:0], sda_s};
        bitcnt <= bitcnt + 1'b1;
      end
      if (scl_rise && state == S_RACK) mack_q <= ~sda_s;
      if (scl_fall) begin
        case (state)
          S_DEV: if (bitcnt == 4'd8) begin
            if (dev_hit) begin
              sda_oe <= 1'b1;
              rw_q   <= rx_sh[0];
              state  <= S_ACK_DEV;
            end else state <= S_WAITP;
          end
          S_ACK_DEV: begin
            bitcnt <= '0;
            if (rw_q) begin
              tx_sh  <= rd_q[6:0];
              sda_oe <= ~rd_q[7];
              state  <= S_RDATA;
            end else begin
              sda_oe <= 1'b0;
              state  <= S_WADDR;
            end
          end
          S_WADDR: if (bitcnt == 4'd8) begin
            cur_addr <= rx_sh;
            sda_oe   <= 1'b1;
            state    <= S_ACK_ADDR;
          end
          S_WDATA: if (bitcnt == 4'd8) begin
            cur_addr <= page_step(cur_addr, page_len);
            byte_cnt <= byte_cnt + 1'b1;
            txn_wr   <= 1'b1;
            sda_oe   <= 1'b1;
            state    <= S_ACK_DATA;
          end
          S_ACK_ADDR, S_ACK_DATA: begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
            state  <= S_WDATA;
          end
          S_RDATA: if (bitcnt == 4'd7) begin
            sda_oe   <= 1'b0;
            cur_addr <= cur_addr + 1'b1;
            byte_cnt <= byte_cnt + 1'b1;
            txn_rd   <= 1'b1;
            state    <= S_RACK;
          end else begin
            bitcnt <= bitcnt + 1'b1;
            sda_oe <= ~tx_sh[6];
            tx_sh  <= {tx_sh[5:0], 1'b0};
          end
          S_RACK: if (mack_q) begin
            tx_sh  <= rd_q[6:0];
            sda_oe <= ~rd_q[7];
            bitcnt <= '0;
            state  <= S_RDATA;
          end else state <= S_WAITP;
          default: ;
        endcase
      end
    end
  end

  AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    byte_in && state == S_WADDR |=> cur_addr == $past(rx_sh)); // R2
  AST_PAGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (cur_addr & ~page_mask($past(page_len)))
                == ($past(cur_addr) & ~page_mask($past(page_len)))); // R4
  AST_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_byte_done |=> cur_addr == MEM_AW'($past(cur_addr) + 1'b1)); // R7
  AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_WAITP |-> !sda_oe); // R7
  AST_BUSY_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(txn_end)); // R8
  AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    busy && state == S_DEV && byte_in |=> !sda_oe); // R8
endmodule

// File: tb/i2cmem_slave_test.sv
`timescale 1ns/1ps
module i2cmem_slave_test;
  localparam logic [6:0] DEV = 7'h50;
  localparam int Q = 20;  // quarter of a bus bit, ns

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1, sda_line;
  logic sda_oe, ram_req, ram_we, ram_ack, reg_wr, reg_rd, irq;
  logic [7:0] ram_addr, ram_wdata, ram_rdata, reg_wdata, reg_rdata;
  logic [2:0] reg_sel;
  assign sda_line = sda_m & ~sda_oe;

  i2cmem_slave uut (
    .clk, .rst_n, .scl_i(scl_m), .sda_i(sda_line), .sda_oe,
    .ram_req, .ram_we, .ram_addr, .ram_wdata, .ram_ack, .ram_rdata,
    .reg_sel, .reg_wr, .reg_rd, .reg_wdata, .reg_rdata, .irq
  );

  logic [7:0] mem [256];
  logic [7:0] expm [256];
  logic [7:0] mptr;
  int checks = 0, errors = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ram_ack <= 1'b0;
      ram_rdata <= 8'd0;
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7 + 3);
    end else begin
      ram_ack <= 1'b0;
      if (ram_req && !ram_ack) begin
        ram_ack <= 1'b1;
        if (ram_we) mem[ram_addr] <= ram_wdata;
        else ram_rdata <= mem[ram_addr];
      end
    end
  end

  function automatic logic [7:0] bf_next(input logic [7:0] a, input logic [1:0] pl);
    int sz;
    sz = 8 << pl;
    return 8'((a / sz) * sz + ((a % sz) + 1) % sz);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic wr_reg(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] s, output logic [7:0] d);
    @(negedge clk); reg_sel = s; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; #Q scl_m = 1'b1; #Q sda_m = 1'b0; #Q scl_m = 1'b0; #Q;
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; #Q scl_m = 1'b1; #Q sda_m = 1'b1; #(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; #Q scl_m = 1'b1; #(2*Q) scl_m = 1'b0; #Q;
    end
    sda_m = 1'b1; #Q scl_m = 1'b1; #Q ack = ~sda_line; #Q scl_m = 1'b0; #Q;
  endtask

  task automatic recv_byte(input logic do_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      #Q scl_m = 1'b1; #Q b[i] = sda_line; #Q scl_m = 1'b0; #Q;
    end
    sda_m = ~do_ack; #Q scl_m = 1'b1; #(2*Q) scl_m = 1'b0; #Q;
  endtask

  task automatic mem_check(input string req);
    int bad;
    bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== expm[i]) bad++;
    chk(req, bad, 0);
  endtask

  // write transaction; leaves the lock set and checks it
  task automatic do_write(input logic [7:0] a, input int n, input logic [1:0] pl);
    logic ack;
    logic [7:0] d, r;
    i2c_start();
    send_byte({DEV, 1'b0}, ack); chk("R1 dev ack", ack, 1);
    send_byte(a, ack); chk("R2 addr ack", ack, 1);
    mptr = a;
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      send_byte(d, ack); chk("R3 data ack", ack, 1);
      expm[mptr] = d;
      mptr = bf_next(mptr, pl);
    end
    i2c_stop();
    repeat (4) @(negedge clk);
    mem_check("R3/R4 memory contents");
    rd_reg(3'd3, r); chk("R9 write count", r, n);
    rd_reg(3'd4, r); chk("R4 pointer after page write", r, mptr);
    rd_reg(3'd1, r); chk("R8 busy after write", r, (n > 0) ? 1 : 0);
    rd_reg(3'd2, r); chk("R10 status after write", r, (n > 0) ? 8'h05 : 8'h04);
  endtask

  task automatic unlock();
    logic [7:0] r;
    wr_reg(3'd1, 8'h00);
    rd_reg(3'd1, r); chk("R8 busy cleared", r, 0);
  endtask

  task automatic do_read(input int n, input string req);
    logic ack;
    logic [7:0] d, r;
    logic [7:0] p0;
    p0 = mptr;
    send_byte({DEV, 1'b1}, ack); chk({req, " read dev ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      chk({req, " read data"}, d, expm[mptr]);
      mptr = mptr + 8'd1;
    end
    #Q chk("R7 released after nack", sda_oe, 0);
    i2c_stop();
    repeat (4) @(negedge clk);
    rd_reg(3'd3, r); chk("R9 read count", r, n);
    rd_reg(3'd4, r); chk("R5 pointer after read", r, 8'(p0 + 8'(n)));
    rd_reg(3'd2, r); chk("R10 status after read", r, 8'h06);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic [7:0] r, a;
    logic ack;
    logic [1:0] pl;
    int n;
    void'($urandom(32'd4242));
    reg_sel = 3'd0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = 8'd0;
    for (int i = 0; i < 256; i++) expm[i] = 8'(i * 7 + 3);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11 reset state
    chk("R11 sda_oe", sda_oe, 0);
    chk("R11 irq", irq, 0);
    chk("R11 ram_req", ram_req, 0);
    for (int s = 0; s < 5; s++) begin
      rd_reg(3'(s), r); chk("R11 register zero", r, 0);
    end

    // R10 interrupt enable, page 8
    wr_reg(3'd0, 8'h01);
    // R1 wrong address ignored
    i2c_start(); send_byte({7'h51, 1'b0}, ack); chk("R1 foreign addr nack", ack, 0);
    send_byte(8'h10, ack); chk("R1 rest ignored", ack, 0);
    i2c_stop();
    rd_reg(3'd2, r); chk("R1 no status", r, 0);
    chk("R10 irq idle", irq, 0);

    // byte write, lock, irq
    do_write(8'h3A, 1, 2'd0);
    // status already read: irq must be low now
    chk("R10 irq cleared by status read", irq, 0);
    // R8 locked slave refuses, count kept (R9)
    i2c_start(); send_byte({DEV, 1'b0}, ack); chk("R8 locked nack", ack, 0);
    i2c_stop();
    rd_reg(3'd3, r); chk("R9 count kept while locked", r, 1);
    wr_reg(3'd1, 8'h01);
    rd_reg(3'd1, r); chk("R8 write 1 no effect", r, 1);
    unlock();

    // R10 irq raised by event while enabled
    i2c_start(); send_byte({DEV, 1'b0}, ack); send_byte(8'h00, ack); i2c_stop();
    repeat (3) @(negedge clk);
    chk("R10 irq high", irq, 1);
    rd_reg(3'd2, r); chk("R10 match flag", r, 8'h04);
    chk("R10 irq low after read", irq, 0);

    // page wrap directed: 64-byte page crossing
    wr_reg(3'd0, 8'hC0);
    do_write(8'h7C, 10, 2'd3); unlock();
    // R5 current-address read continues after write
    i2c_start(); do_read(3, "R5");

    // R6 random read with repeated start
    a = 8'h20;
    i2c_start(); send_byte({DEV, 1'b0}, ack); send_byte(a, ack);
    chk("R6 dummy addr ack", ack, 1);
    mptr = a;
    i2c_start(); do_read(4, "R6 restart");
    // R6 dummy write + stop then separate read
    i2c_start(); send_byte({DEV, 1'b0}, ack); send_byte(a, ack); i2c_stop();
    rd_reg(3'd2, r);
    mptr = a;
    i2c_start(); do_read(4, "R6 split");

    // R7 roll-over 0xFF -> 0x00
    i2c_start(); send_byte({DEV, 1'b0}, ack); send_byte(8'hFE, ack);
    mptr = 8'hFE;
    i2c_start(); do_read(4, "R7 rollover");

    // random mix
    for (int k = 0; k < 10; k++) begin
      pl = 2'($urandom);
      wr_reg(3'd0, {pl, 6'd0});
      a = 8'($urandom);
      n = 1 + int'($urandom % 20);
      do_write(a, n, pl); unlock();
      a = 8'($urandom);
      i2c_start(); send_byte({DEV, 1'b0}, ack); send_byte(a, ack);
      mptr = a;
      i2c_start(); do_read(1 + int'($urandom % 8), "R7 random seq");
    end
    summary();
  end
endmodule